// File: doc/BRIEF.md
# Modular Key Power Generator

This block accepts a 130-bit key value `r` and produces the table of its powers `r^1` to `r^8`, all taken modulo the prime 2^130-5. Such a table lets a downstream hashing datapath fold eight message blocks in parallel, each one scaled by its own power of the key.

Four iterative multiply-and-reduce units work side by side. A small controller runs them through three dependency rounds: `r^2` first, then `r^3` and `r^4`, then `r^5` to `r^8`. Every round reuses powers that earlier rounds already produced. The finished table goes into an output FIFO that holds two tables. Key arrival and table consumption are therefore decoupled, and the generator can work ahead of a slow consumer or behind a fast one.

A key enters on a valid/ready handshake. The block takes a new key only when it is idle and the FIFO has room. Tables leave on a second valid/ready handshake.

Top module: `kpg_top`

## Requirements
- R1: Field 0 of the output table (bits 129:0) carries the accepted key exactly as it was presented, with no reduction, even when the key is at or above the prime.
- R2: For k = 2 to 8, the field at bits (k-1)*130 +: 130 of the output table equals r^k mod (2^130-5).
- R3: Every computed power (k of 2 or more) is fully reduced into the range 0 to 2^130-6. A key at or above the prime is reduced before it is multiplied, so a key of prime+2 gives r^2 = 4.
- R4: key_ready is low from the cycle after a key is accepted until that key's table has been pushed into the FIFO.
- R5: key_ready is low while the FIFO holds two tables, and a key presented during that time is not taken.
- R6: Tables leave in the order their keys were accepted. An entry is removed only on a cycle with pow_valid and pow_ready both high, and while pow_ready is low the presented table stays stable.
- R7: A key of 0 gives zero in every field, and a key of 1 gives one in every field.
- R8: After reset, key_ready is high and pow_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| key_valid | input | 1 | A key is presented |
| key_ready | output | 1 | The block takes the presented key on this edge |
| key_r | input | 130 | Key value r |
| pow_valid | output | 1 | A power table is available |
| pow_ready | input | 1 | The consumer takes the table on this edge |
| pow_table | output | 1040 | Eight 130-bit powers; r^k sits at bits (k-1)*130 +: 130 |

## Verification
A wrong round schedule or a wrong operand choice corrupts the high fields (r^5 to r^8) first, because they depend on every earlier round. The error shows in the first table after the offending key, about 400 cycles after that key is accepted. A reduction fault shows only for certain operands, so the key vectors include the prime boundary and values above it. A FIFO pointer or count error shows as a missing, repeated or reordered table, or as key_ready opening while two tables are still waiting. These are checked with the consumer held off.

// File: rtl/kpg_pkg.sv
package kpg_pkg;
  localparam int W    = 130;
  localparam int NPOW = 8;
  localparam int NMUL = 4;
  localparam logic [W-1:0] PRIME = {{(W-3){1'b1}}, 3'b011};

  typedef enum logic [2:0] {S_IDLE, S_R1, S_R2, S_R3, S_PUSH} state_t;

  // One multiplier job: operand A index, operand B index, destination index (k-1).
  typedef struct packed {
    logic       used;
    logic [2:0] a;
    logic [2:0] b;
    logic [2:0] d;
  } step_t;

  function automatic logic [W-1:0] fold_in(input logic [W-1:0] x);
    return (x >= PRIME) ? x - PRIME : x;
  endfunction

  // acc' = (2*acc + bit*a) mod p, for acc < p and a < p
  function automatic logic [W-1:0] mac_step(input logic [W-1:0] acc,
                                            input logic [W-1:0] a,
                                            input logic         bitv);
    logic [W+1:0] t;
    t = {1'b0, acc, 1'b0} + (bitv ? {2'b00, a} : '0);
    if (t >= {1'b0, PRIME, 1'b0})    t = t - {1'b0, PRIME, 1'b0};
    else if (t >= {2'b00, PRIME})    t = t - {2'b00, PRIME};
    return t[W-1:0];
  endfunction

  // Dependency schedule: indices are k-1 of r^k.
  function automatic step_t plan_step(input state_t s, input int i);
    step_t e;
    e = '0;
    case (s)
      S_R1: if (i == 0) e = '{1'b1, 3'd0, 3'd0, 3'd1};
      S_R2: case (i)
              0: e = '{1'b1, 3'd0, 3'd1, 3'd2};
              1: e = '{1'b1, 3'd1, 3'd1, 3'd3};
              default: e = '0;
            endcase
      S_R3: case (i)
              0: e = '{1'b1, 3'd3, 3'd0, 3'd4};
              1: e = '{1'b1, 3'd1, 3'd3, 3'd5};
              2: e = '{1'b1, 3'd2, 3'd3, 3'd6};
              default: e = '{1'b1, 3'd3, 3'd3, 3'd7};
            endcase
      default: e = '0;
    endcase
    return e;
  endfunction
endpackage

// File: rtl/kpg_modmul.sv
module kpg_modmul
  import kpg_pkg::*;
#(
  parameter int WD = W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [WD-1:0] op_a,
  input  logic [WD-1:0] op_b,
  output logic          busy,
  output logic          done,
  output logic [WD-1:0] result
);
  localparam int CW = $clog2(WD + 1);

  logic [WD-1:0] a_q, b_q, acc;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      done <= 1'b0;
      cnt  <= '0;
      acc  <= '0;
      a_q  <= '0;
      b_q  <= '0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        acc  <= '0;
        a_q  <= fold_in(op_a);
        b_q  <= op_b;
        cnt  <= CW'(WD);
        busy <= 1'b1;
      end else if (busy) begin
        acc <= mac_step(acc, a_q, b_q[WD-1]);
        b_q <= b_q << 1;
        cnt <= cnt - 1'b1;
        if (cnt == CW'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  assign result = acc;

  AST_RESULT_REDUCED: assert property (@(posedge clk) disable iff (rst)
    done |-> (result < PRIME)); // R3
endmodule

// File: rtl/kpg_fifo.sv
module kpg_fifo #(
  parameter int DW    = 1040,
  parameter int DEPTH = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [DW-1:0] din,
  output logic          full,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] dout
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic          pop;

  assign full      = (count == CW'(DEPTH));
  assign out_valid = (count != '0);
  assign pop       = out_valid && out_ready;
  assign dout      = mem[rd_ptr];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) begin
        mem[wr_ptr] <= din;
        wr_ptr      <= bump(wr_ptr);
      end
      if (pop) rd_ptr <= bump(rd_ptr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    push |-> !full); // R5
  AST_OUT_HELD: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(dout))); // R6
endmodule

// File: rtl/kpg_sched.sv
module kpg_sched
  import kpg_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             accept,
  input  logic [W-1:0]     key,
  output logic             idle,
  output logic             push,
  output logic [NPOW*W-1:0] table_out
);
  state_t          state;
  logic            go_q;
  logic [NMUL-1:0] seen, used, done, busy, start;
  logic [W-1:0]    pw  [NPOW];
  logic [W-1:0]    res [NMUL];
  step_t           ent [NMUL];
  logic            round_done;

  for (genvar i = 0; i < NMUL; i++) begin : g_mul
    assign ent[i]   = plan_step(state, i);
    assign used[i]  = ent[i].used;
    assign start[i] = go_q && used[i];

    kpg_modmul #(.WD(W)) u_mul (
      .clk    (clk),
      .rst    (rst),
      .start  (start[i]),
      .op_a   (pw[ent[i].a]),
      .op_b   (pw[ent[i].b]),
      .busy   (busy[i]),
      .done   (done[i]),
      .result (res[i])
    );
  end

  assign round_done = (used != '0) && (((seen | done) & used) == used);
  assign idle       = (state == S_IDLE);
  assign push       = (state == S_PUSH);

  always_comb begin
    for (int k = 0; k < NPOW; k++) table_out[k*W +: W] = pw[k];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE;
      go_q  <= 1'b0;
      seen  <= '0;
      for (int k = 0; k < NPOW; k++) pw[k] <= '0;
    end else begin
      go_q <= 1'b0;
      case (state)
        S_IDLE: if (accept) begin
          pw[0] <= key;
          for (int k = 1; k < NPOW; k++) pw[k] <= '0;
          seen  <= '0;
          go_q  <= 1'b1;
          state <= S_R1;
        end
        S_R1, S_R2, S_R3: begin
          seen <= seen | done;
          for (int i = 0; i < NMUL; i++)
            if (done[i] && used[i]) pw[ent[i].d] <= res[i];
          if (round_done) begin
            seen <= '0;
            if (state == S_R3) state <= S_PUSH;
            else begin
              state <= (state == S_R1) ? S_R2 : S_R3;
              go_q  <= 1'b1;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_MULS_IDLE_AT_GO: assert property (@(posedge clk) disable iff (rst)
    go_q |-> (busy == '0)); // R4
  AST_KEY_FIELD_KEPT: assert property (@(posedge clk) disable iff (rst)
    (!idle && $past(!idle)) |-> $stable(pw[0])); // R1
  AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (rst)
    (busy != '0) |-> !accept); // R4
endmodule

// File: rtl/kpg_top.sv
module kpg_top
  import kpg_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                key_valid,
  output logic                key_ready,
  input  logic [129:0]        key_r,
  output logic                pow_valid,
  input  logic                pow_ready,
  output logic [1039:0]       pow_table
);
  localparam int TBL_DEPTH = 2;

  logic              sched_idle, sched_push, fifo_full, accept;
  logic [NPOW*W-1:0] tbl;

  assign key_ready = sched_idle && !fifo_full;
  assign accept    = key_valid && key_ready;

  kpg_sched u_sched (
    .clk       (clk),
    .rst       (rst),
    .accept    (accept),
    .key       (key_r),
    .idle      (sched_idle),
    .push      (sched_push),
    .table_out (tbl)
  );

  kpg_fifo #(.DW(NPOW*W), .DEPTH(TBL_DEPTH)) u_fifo (
    .clk       (clk),
    .rst       (rst),
    .push      (sched_push),
    .din       (tbl),
    .full      (fifo_full),
    .out_valid (pow_valid),
    .out_ready (pow_ready),
    .dout      (pow_table)
  );

  AST_PUSH_THEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    sched_push |=> (sched_idle && pow_valid)); // R4
endmodule

// File: tb/tb_kpg_top.sv
module tb_kpg_top;
  localparam int WB = 130;
  localparam logic [WB-1:0] P = {{(WB-3){1'b1}}, 3'b011};
  localparam int NK = 8;
  localparam logic [WB-1:0] KEYS [NK] = '{
    130'h0, 130'h1, 130'h2, P - 130'h1, P + 130'h2, {WB{1'b1}},
    130'h1_0f1e2d3c_4b5a6978_8796a5b4_c3d2e1f0,
    130'h2_deadbeef_01234567_89abcdef_fedcba98
  };

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           key_valid = 1'b0;
  logic           key_ready;
  logic [WB-1:0]  key_r = '0;
  logic           pow_valid;
  logic           pow_ready = 1'b0;
  logic [8*WB-1:0] pow_table;
  int checks = 0, errors = 0, cyc = 0;

  always #4 clk = ~clk;

  kpg_top dut (.clk(clk), .rst(rst), .key_valid(key_valid), .key_ready(key_ready),
               .key_r(key_r), .pow_valid(pow_valid), .pow_ready(pow_ready),
               .pow_table(pow_table));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // Reference: schoolbook product, folded with 2^130 = 5 (mod p)
  function automatic logic [WB-1:0] ref_mul(input logic [WB-1:0] a, input logic [WB-1:0] b);
    logic [2*WB+3:0] x;
    logic [WB-1:0] aa, bb;
    aa = (a >= P) ? a - P : a;
    bb = (b >= P) ? b - P : b;
    x = {4'b0, WB'(0), aa} * {4'b0, WB'(0), bb};
    while ((x >> WB) != 0) x = (x & {{(WB+4){1'b0}}, {WB{1'b1}}}) + 5 * (x >> WB);
    if (x[WB-1:0] >= P) x = x - {{(WB+4){1'b0}}, P};
    return x[WB-1:0];
  endfunction

  function automatic logic [WB-1:0] ref_pow(input logic [WB-1:0] r, input int k);
    logic [WB-1:0] acc, base;
    if (k == 1) return r;
    acc = 130'h1;
    base = (r >= P) ? r - P : r;
    for (int e = k; e > 0; e = e >> 1) begin
      if (e[0]) acc = ref_mul(acc, base);
      base = ref_mul(base, base);
    end
    return acc;
  endfunction

  task automatic chk(input logic [WB-1:0] act, input logic [WB-1:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [WB-1:0] k);
    @(negedge clk);
    key_r = k;
    key_valid = 1'b1;
    while (!key_ready) @(negedge clk);
    @(negedge clk);
    key_valid = 1'b0;
  endtask

  task automatic check_table(input logic [WB-1:0] r, input string tag);
    while (!pow_valid) @(negedge clk);
    for (int k = 1; k <= 8; k++)
      chk(pow_table[(k-1)*WB +: WB], ref_pow(r, k),
          $sformatf("%s R1/R2 power %0d", tag, k));
    pow_ready = 1'b1;
    @(negedge clk);
    pow_ready = 1'b0;
  endtask

  initial begin
    logic [8*WB-1:0] held;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(WB'(key_ready), 130'h1, "R8 key_ready after reset");
    chk(WB'(pow_valid), 130'h0, "R8 pow_valid after reset");

    for (int i = 0; i < NK; i++) begin
      send(KEYS[i]);
      chk(WB'(key_ready), 130'h0, "R4 key_ready low while computing");
      check_table(KEYS[i], $sformatf("key%0d", i));
    end

    // directed corners (R3, R7)
    send(P + 130'h2);
    while (!pow_valid) @(negedge clk);
    chk(pow_table[WB +: WB], 130'h4, "R3 reduced square of prime+2");
    chk(pow_table[7*WB +: WB], 130'h100, "R3 reduced eighth power of prime+2");
    pow_ready = 1'b1; @(negedge clk); pow_ready = 1'b0;
    send(130'h0);
    while (!pow_valid) @(negedge clk);
    chk(pow_table[7*WB +: WB], 130'h0, "R7 zero key");
    pow_ready = 1'b1; @(negedge clk); pow_ready = 1'b0;
    send(130'h1);
    while (!pow_valid) @(negedge clk);
    chk(pow_table[5*WB +: WB], 130'h1, "R7 unit key");
    pow_ready = 1'b1; @(negedge clk); pow_ready = 1'b0;

    // FIFO full, hold and order (R5, R6)
    send(KEYS[6]);
    send(KEYS[7]);
    repeat (500) @(negedge clk);
    chk(WB'(key_ready), 130'h0, "R5 key_ready low with two tables");
    held = pow_table;
    key_r = 130'h3;
    key_valid = 1'b1;
    repeat (20) @(negedge clk);
    chk(WB'(key_ready), 130'h0, "R5 key not taken while full");
    chk(pow_table[0 +: WB], held[0 +: WB], "R6 table stable while not ready");
    chk(pow_table[7*WB +: WB], held[7*WB +: WB], "R6 top field stable");
    key_valid = 1'b0;
    check_table(KEYS[6], "R6 first in order");
    send(130'h3);
    check_table(KEYS[7], "R6 second in order");
    check_table(130'h3, "R6 third after full");
    @(negedge clk);
    chk(WB'(pow_valid), 130'h0, "R6 FIFO empty after pops");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule